// File: doc/BRIEF.md
# EDO DRAM Strobe Protocol Decoder

This block is a synchronous, device-side model of an EDO dynamic RAM. It samples the active-low row strobe, column strobe, write enable and output enable on every clock, along with a multiplexed address bus and a data input bus. It works out which kind of memory cycle is in progress from the order in which the strobe edges arrive, not from any command code. It stores written words in a small internal array, returns read words and drives a data-pin output enable. It also keeps the internal row counter used for refreshes where the controller supplies no row. A controller under test can be wired to it in simulation, and every cycle it decodes is reported on an operation pulse with a kind code.

The decoder is a state machine with ten states. ST_IDLE has both strobes high. ST_CAS_LEAD means the column strobe fell while the row strobe was high. ST_CAS_TAIL means the row strobe rose while the column strobe stayed low. ST_ROW_OPEN means a row is latched and no column access has happened yet. ST_COL_READ and ST_COL_WRITE mean the column strobe is low during an access. ST_PAGE means the column strobe rose after an access while the row stayed open. ST_CBR, ST_TEST and ST_SELF cover counter refresh, test entry and self-refresh.

The transitions are:
- ST_IDLE goes to ST_ROW_OPEN when the row strobe falls with the column strobe high.
- ST_IDLE goes to ST_CAS_LEAD when the column strobe falls.
- ST_IDLE, ST_CAS_LEAD and ST_CAS_TAIL go to ST_CBR or ST_TEST when the row strobe falls with the column strobe low. Write enable high selects ST_CBR and write enable low selects ST_TEST.
- ST_ROW_OPEN and ST_PAGE go to ST_COL_READ or ST_COL_WRITE on a column strobe fall. Write enable high selects ST_COL_READ and write enable low selects ST_COL_WRITE.
- ST_COL_READ and ST_COL_WRITE go to ST_PAGE when the column strobe rises.
- ST_ROW_OPEN and ST_PAGE go to ST_IDLE when the row strobe rises.
- ST_CBR goes to ST_SELF after a long low row strobe.
- ST_COL_READ, ST_COL_WRITE, ST_CBR, ST_TEST and ST_SELF go to ST_CAS_TAIL or ST_IDLE when the row strobe rises. ST_CAS_TAIL is chosen if the column strobe is still low.
- ST_CAS_LEAD and ST_CAS_TAIL go to ST_IDLE when the column strobe rises.

All results are registered. An output reflects the inputs sampled at the rising clock edge where the change is first seen, and appears just after that edge.

Top module: `edo_strobe_decoder`

## Requirements
- R1: A column strobe fall while a row is open and write enable is high is a read. It pulses `op_valid` with `op_kind` 0 and loads `dout` with the word at the latched row and the column on `addr`. `dq_oe` follows the held-data flag gated by `oe_n` low.
- R2: A column strobe fall while a row is open and write enable is low is an early write. It stores `din` at the latched row and column and pulses `op_valid` with `op_kind` 1. `dq_oe` stays low.
- R3: A row strobe that falls with the column strobe high and rises with no column access in between is a row-only refresh. It reports `op_kind` 2, loads `refresh_row` with the row latched at the fall, and leaves the internal counter unchanged.
- R4: A row strobe fall with the column strobe low and write enable high is a counter refresh. It reports `op_kind` 3, loads `refresh_row` with the counter, and advances the counter by one. The counter is ROW_W bits wide and wraps to zero.
- R5: A row strobe fall with both the column strobe and write enable low is test-mode entry. It reports `op_kind` 5, refreshes no row and leaves the counter unchanged.
- R6: Read data keeps being driven after the column strobe rises. The held data is dropped in any clock where both strobes are sampled high, or where write enable falls. While `oe_n` is high, `dq_oe` is low.
- R7: A counter refresh that starts while read data is held is a hidden refresh. In that case the row strobe rose and fell again with the column strobe kept low after a read. It reports `op_kind` 4, refreshes and advances the counter as in R4, and keeps `dout` and `dq_oe` unchanged.
- R8: A counter refresh whose row strobe is still sampled low SR_CYCLES clocks after the fall enters self-refresh. This pulses `op_kind` 6 and sets `self_refresh`, which clears at the clock where the row strobe is sampled high.
- R9: A column strobe that falls and then rises while the row strobe stays high, with no row strobe fall in between, pulses `proto_err`. The same strobe ending a counter or hidden refresh does not.
- R10: In page mode, a second and later column access while the row strobe stays low uses the row latched at the row strobe fall. Reads and writes may be mixed in one page.
- R11: After reset, all outputs are zero, the array reads as zero and the counter is zero. `op_valid` is high only in the clock after a decision edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | DATA_W | Write data from the pins |
| dout | output | DATA_W | Held read data |
| dq_oe | output | 1 | Data pins driven |
| op_valid | output | 1 | One-clock pulse per decoded operation |
| op_kind | output | 3 | Operation code, see R1 to R8 |
| refresh_row | output | ROW_W | Row of the most recent refresh |
| self_refresh | output | 1 | Self-refresh active |
| proto_err | output | 1 | One-clock pulse on a stray column strobe |

## Verification
The bench builds the decoder with a 3-bit row and 3-bit column address, 8-bit data and a self-refresh threshold of 12 clocks. The narrow row field lets a run of nine counter refreshes carry the counter all the way around and back past zero. The short threshold makes self-refresh entry reachable, and its exact entry clock checkable on both sides, in a few dozen cycles instead of twenty thousand. A behavioural model fed the same pins is compared against every output on each clock, alongside directed checks on page mode, hidden refresh and the release rules.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    typedef enum logic [2:0] {
        OP_READ           = 3'd0,
        OP_WRITE          = 3'd1,
        OP_ROW_REFRESH    = 3'd2,
        OP_CBR_REFRESH    = 3'd3,
        OP_HIDDEN_REFRESH = 3'd4,
        OP_TEST_ENTRY     = 3'd5,
        OP_SELF_REFRESH   = 3'd6
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAS_LEAD,
        ST_CAS_TAIL,
        ST_ROW_OPEN,
        ST_COL_READ,
        ST_COL_WRITE,
        ST_PAGE,
        ST_CBR,
        ST_TEST,
        ST_SELF
    } dram_state_e;

endpackage

// File: rtl/edo_strobe_sampler.sv
`timescale 1ns/1ps
module edo_strobe_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic cas_rise,
    output logic we_fall
);
    logic ras_q, cas_q, we_q;

    // Previous samples; strobes idle high out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_q & ~cas_n;
    assign cas_rise = ~cas_q & cas_n;
    assign we_fall  = we_q & ~we_n;

endmodule

// File: rtl/edo_refresh_ctr.sv
`timescale 1ns/1ps
module edo_refresh_ctr #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       row <= '0;
        else if (advance) row <= row + 1'b1;
    end
endmodule

// File: rtl/edo_cell_array.sv
`timescale 1ns/1ps
module edo_cell_array #(
    parameter int AW     = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[idx] <= wr_data;
        end
    end

    assign rd_data = cells[idx];
endmodule

// File: rtl/edo_cycle_fsm.sv
`timescale 1ns/1ps
module edo_cycle_fsm
    import edo_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int ADDR_W    = 4,
    parameter int SR_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              data_held,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row_q,
    output logic              op_fire,
    output op_kind_e          op_kind,
    output logic              err_fire,
    output logic              mem_wr,
    output logic              rd_capture,
    output logic              ror_fire,
    output logic              cbr_fire,
    output logic              in_self
);
    localparam int SR_W = $clog2(SR_CYCLES + 1);
    localparam logic [SR_W-1:0] SR_LAST = SR_W'(SR_CYCLES - 1);

    dram_state_e     state_q, state_d;
    logic [SR_W-1:0] sr_cnt_q;
    logic            row_load, sr_clear, sr_step;

    // State register, latched row and self-refresh timer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            row_q    <= '0;
            sr_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (row_load) row_q <= addr[ROW_W-1:0];
            if (sr_clear)     sr_cnt_q <= '0;
            else if (sr_step) sr_cnt_q <= sr_cnt_q + 1'b1;
        end
    end

    // Next state and per-edge actions.
    always_comb begin
        state_d    = state_q;
        op_fire    = 1'b0;
        op_kind    = OP_READ;
        err_fire   = 1'b0;
        mem_wr     = 1'b0;
        rd_capture = 1'b0;
        ror_fire   = 1'b0;
        cbr_fire   = 1'b0;
        row_load   = 1'b0;
        sr_clear   = 1'b0;
        sr_step    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CAS_LEAD, ST_CAS_TAIL: begin
                if (ras_fall && cas_n) begin
                    row_load = 1'b1;
                    state_d  = ST_ROW_OPEN;
                end else if (ras_fall) begin
                    op_fire = 1'b1;
                    if (we_n) begin
                        cbr_fire = 1'b1;
                        sr_clear = 1'b1;
                        op_kind  = data_held ? OP_HIDDEN_REFRESH : OP_CBR_REFRESH;
                        state_d  = ST_CBR;
                    end else begin
                        op_kind = OP_TEST_ENTRY;
                        state_d = ST_TEST;
                    end
                end else if (state_q == ST_IDLE) begin
                    if (cas_fall) state_d = ST_CAS_LEAD;
                end else if (cas_rise) begin
                    err_fire = (state_q == ST_CAS_LEAD);
                    state_d  = ST_IDLE;
                end
            end
            ST_ROW_OPEN, ST_PAGE: begin
                if (ras_rise) begin
                    if (state_q == ST_ROW_OPEN) begin
                        ror_fire = 1'b1;
                        op_fire  = 1'b1;
                        op_kind  = OP_ROW_REFRESH;
                    end
                    state_d = ST_IDLE;
                end else if (cas_fall) begin
                    op_fire = 1'b1;
                    if (!we_n) begin
                        mem_wr  = 1'b1;
                        op_kind = OP_WRITE;
                        state_d = ST_COL_WRITE;
                    end else begin
                        rd_capture = 1'b1;
                        op_kind    = OP_READ;
                        state_d    = ST_COL_READ;
                    end
                end
            end
            ST_COL_READ, ST_COL_WRITE: begin
                if (ras_rise)      state_d = cas_n ? ST_IDLE : ST_CAS_TAIL;
                else if (cas_rise) state_d = ST_PAGE;
            end
            ST_CBR: begin
                if (ras_rise) begin
                    state_d = cas_n ? ST_IDLE : ST_CAS_TAIL;
                end else if (sr_cnt_q == SR_LAST) begin
                    op_fire = 1'b1;
                    op_kind = OP_SELF_REFRESH;
                    state_d = ST_SELF;
                end else begin
                    sr_step = 1'b1;
                end
            end
            ST_TEST, ST_SELF: begin
                if (ras_rise) state_d = cas_n ? ST_IDLE : ST_CAS_TAIL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_self = (state_q == ST_SELF);

    // R3: a row-only refresh never follows a column access in the same cycle.
    assert_ror_no_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_capture || mem_wr) |=> !ror_fire);

    // R9: the stray-strobe flag only fires from the column-lead state.
    assert_err_from_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_fire |-> (state_q == ST_CAS_LEAD) && cas_rise);

endmodule

// File: rtl/edo_strobe_decoder.sv
`timescale 1ns/1ps
module edo_strobe_decoder
    import edo_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int SR_CYCLES = 20000
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       ras_n,
    input  logic                                       cas_n,
    input  logic                                       we_n,
    input  logic                                       oe_n,
    input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
    input  logic [DATA_W-1:0]                          din,
    output logic [DATA_W-1:0]                          dout,
    output logic                                       dq_oe,
    output logic                                       op_valid,
    output logic [2:0]                                 op_kind,
    output logic [ROW_W-1:0]                           refresh_row,
    output logic                                       self_refresh,
    output logic                                       proto_err
);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int MEM_AW = ROW_W + COL_W;

    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic [ROW_W-1:0]  row_q, ctr_row;
    logic              op_fire, err_fire, mem_wr, rd_capture, ror_fire, cbr_fire, in_self;
    op_kind_e          kind_c, kind_q;
    logic [DATA_W-1:0] rd_data;
    logic              held_q, held_d;

    edo_strobe_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
    );

    edo_cycle_fsm #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .SR_CYCLES(SR_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise),
        .data_held(held_q), .addr(addr), .row_q(row_q),
        .op_fire(op_fire), .op_kind(kind_c), .err_fire(err_fire),
        .mem_wr(mem_wr), .rd_capture(rd_capture),
        .ror_fire(ror_fire), .cbr_fire(cbr_fire), .in_self(in_self)
    );

    edo_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .advance(cbr_fire), .row(ctr_row)
    );

    edo_cell_array #(.AW(MEM_AW), .DATA_W(DATA_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_wr),
        .idx({row_q, addr[COL_W-1:0]}), .wr_data(din), .rd_data(rd_data)
    );

    // Held-data flag: set by a read, dropped when both strobes are high or WE falls.
    always_comb begin
        if (rd_capture)                     held_d = 1'b1;
        else if ((ras_n && cas_n) || we_fall) held_d = 1'b0;
        else                                held_d = held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q      <= 1'b0;
            dout        <= '0;
            dq_oe       <= 1'b0;
            op_valid    <= 1'b0;
            kind_q      <= OP_READ;
            proto_err   <= 1'b0;
            refresh_row <= '0;
        end else begin
            held_q    <= held_d;
            dq_oe     <= held_d && !oe_n;
            op_valid  <= op_fire;
            proto_err <= err_fire;
            if (op_fire)    kind_q <= kind_c;
            if (rd_capture) dout   <= rd_data;
            if (ror_fire)      refresh_row <= row_q;
            else if (cbr_fire) refresh_row <= ctr_row;
        end
    end

    assign op_kind      = kind_q;
    assign self_refresh = in_self;

    // R2: an early write never turns the pins around.
    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind_q == OP_WRITE) |-> !dq_oe);

    // R6: output enable high releases the pins on the next clock.
    assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_oe);

    // R6: both strobes high releases the pins on the next clock.
    assert_strobe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> !dq_oe);

    // R4: after a counter or hidden refresh the counter sits one past the reported row.
    assert_counter_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (kind_q == OP_CBR_REFRESH || kind_q == OP_HIDDEN_REFRESH))
        |-> (ctr_row == ROW_W'(refresh_row + 1'b1)));

    // R8: self-refresh ends once the row strobe is seen high.
    assert_self_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (self_refresh && ras_n) |=> !self_refresh);

endmodule

// File: tb/edo_strobe_decoder_tb.sv
`timescale 1ns/1ps
module edo_strobe_decoder_tb;
    localparam int ROW_W = 3, COL_W = 3, DATA_W = 8, SR = 12;
    localparam int NROWS = 1 << ROW_W, NCOLS = 1 << COL_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dq_oe, op_valid, self_refresh, proto_err;
    logic [2:0] op_kind;
    logic [2:0] refresh_row;

    edo_strobe_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .SR_CYCLES(SR)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe), .op_valid(op_valid),
        .op_kind(op_kind), .refresh_row(refresh_row), .self_refresh(self_refresh),
        .proto_err(proto_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    localparam int MD_NONE = 0, MD_OPEN = 1, MD_CBR = 2, MD_TEST = 3, MD_SELF = 4;
    int  m_mem [NROWS*NCOLS];
    bit  m_pr, m_pc, m_pw, m_ras_low, m_lead, m_col, m_held;
    int  m_mode, m_row, m_cnt, m_k, m_data;
    bit  e_valid, e_err, e_self, e_oe;
    int  e_kind, e_row;

    function automatic string kind_tag(int k);
        case (k)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4: return "R7"; 5: return "R5"; default: return "R8";
        endcase
    endfunction

    task automatic model_step();
        bit rf, rr, cf, cr, wf, cap;
        int idx;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_pr = 1; m_pc = 1; m_pw = 1; m_ras_low = 0; m_lead = 0; m_col = 0; m_held = 0;
            m_mode = MD_NONE; m_row = 0; m_cnt = 0; m_k = 0; m_data = 0;
            e_valid = 0; e_err = 0; e_self = 0; e_oe = 0; e_kind = 0; e_row = 0;
            return;
        end
        rf = m_pr && !ras_n; rr = !m_pr && ras_n;
        cf = m_pc && !cas_n; cr = !m_pc && cas_n; wf = m_pw && !we_n;
        e_valid = 0; e_err = 0; cap = 0;
        if (!m_ras_low) begin
            if (rf) begin
                m_ras_low = 1; m_lead = 0;
                if (!cas_n) begin
                    e_valid = 1;
                    if (we_n) begin
                        e_kind = m_held ? 4 : 3; e_row = m_cnt;
                        m_cnt = (m_cnt + 1) % NROWS; m_mode = MD_CBR; m_k = 0;
                    end else begin
                        e_kind = 5; m_mode = MD_TEST;
                    end
                end else begin
                    m_row = addr % NROWS; m_mode = MD_OPEN; m_col = 0;
                end
            end else if (cf) m_lead = 1;
            else if (cr) begin
                if (m_lead) e_err = 1;
                m_lead = 0;
            end
        end else begin
            if (rr) begin
                if (m_mode == MD_OPEN && !m_col) begin
                    e_valid = 1; e_kind = 2; e_row = m_row;
                end
                m_ras_low = 0; m_mode = MD_NONE; e_self = 0; m_lead = 0;
            end else if (m_mode == MD_CBR) begin
                if (m_k == SR - 1) begin
                    e_valid = 1; e_kind = 6; m_mode = MD_SELF; e_self = 1;
                end else m_k++;
            end else if (m_mode == MD_OPEN && cf) begin
                m_col = 1; e_valid = 1;
                idx = m_row * NCOLS + (addr % NCOLS);
                if (!we_n) begin e_kind = 1; m_mem[idx] = din; end
                else begin e_kind = 0; cap = 1; m_data = m_mem[idx]; end
            end
        end
        if (cap) m_held = 1;
        else if ((ras_n && cas_n) || wf) m_held = 0;
        e_oe = m_held && !oe_n;
        m_pr = ras_n; m_pc = cas_n; m_pw = we_n;
    endtask

    always @(posedge clk) begin
        model_step();
        #1;
        check(e_valid ? kind_tag(e_kind) : "R11", "op_valid", op_valid, e_valid);
        if (e_valid) check(kind_tag(e_kind), "op_kind", op_kind, e_kind);
        check("R6", "dq_oe", dq_oe, e_oe);
        check("R1", "dout", dout, m_data);
        check("R4", "refresh_row", refresh_row, e_row);
        check("R8", "self_refresh", self_refresh, e_self);
        check("R9", "proto_err", proto_err, e_err);
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R11", "reset dq_oe", dq_oe, 0);
        check("R11", "reset refresh_row", refresh_row, 0);
        check("R11", "reset self_refresh", self_refresh, 0);

        // Early write row 2 col 5
        ras_n = 0; addr = 3'd2; tick(2);
        we_n = 0; din = 8'hA5; tick(1);
        cas_n = 0; addr = 3'd5; tick(1);
        check("R2", "write kind", op_kind, 1);
        check("R2", "write no drive", dq_oe, 0);
        cas_n = 1; tick(1);
        we_n = 1; ras_n = 1; tick(2);

        // Read, EDO hold, page write and read
        ras_n = 0; addr = 3'd2; oe_n = 0; tick(2);
        cas_n = 0; addr = 3'd5; tick(1);
        check("R1", "read kind", op_kind, 0);
        check("R1", "read data", dout, 8'hA5);
        check("R1", "read drive", dq_oe, 1);
        cas_n = 1; tick(2);
        check("R6", "hold after CAS high", dq_oe, 1);
        we_n = 0; din = 8'h3C; tick(1);
        check("R6", "WE fall release", dq_oe, 0);
        cas_n = 0; addr = 3'd3; tick(1);
        check("R10", "page write kind", op_kind, 1);
        cas_n = 1; tick(1);
        we_n = 1; tick(1);
        cas_n = 0; addr = 3'd5; tick(1);
        check("R10", "page read data", dout, 8'hA5);
        oe_n = 1; tick(1);
        check("R6", "OE high release", dq_oe, 0);
        oe_n = 0; tick(1);
        check("R6", "OE low drives again", dq_oe, 1);
        cas_n = 1; tick(1);
        ras_n = 1; tick(1);
        check("R6", "both strobes high release", dq_oe, 0);

        // Row-only refresh
        ras_n = 0; addr = 3'd6; tick(3);
        ras_n = 1; tick(1);
        check("R3", "ror kind", op_kind, 2);
        check("R3", "ror row", refresh_row, 6);

        // Counter refresh and wrap
        cas_n = 0; tick(2);
        ras_n = 0; tick(1);
        check("R4", "cbr kind", op_kind, 3);
        check("R4", "cbr row", refresh_row, 0);
        ras_n = 1; tick(1);
        cas_n = 1; tick(1);
        check("R9", "no error after cbr", proto_err, 0);
        for (int i = 1; i <= NROWS; i++) begin
            cas_n = 0; tick(1);
            ras_n = 0; tick(1);
            check("R4", "cbr row sequence", refresh_row, i % NROWS);
            ras_n = 1; tick(1);
            cas_n = 1; tick(1);
        end

        // Test-mode entry leaves counter alone
        cas_n = 0; we_n = 0; tick(1);
        ras_n = 0; tick(1);
        check("R5", "test kind", op_kind, 5);
        ras_n = 1; tick(1);
        cas_n = 1; we_n = 1; tick(1);
        cas_n = 0; tick(1);
        ras_n = 0; tick(1);
        check("R5", "counter unchanged by test", refresh_row, 1);
        ras_n = 1; tick(1);
        cas_n = 1; tick(1);

        // Hidden refresh
        ras_n = 0; addr = 3'd2; oe_n = 0; tick(2);
        cas_n = 0; addr = 3'd3; tick(1);
        check("R10", "page-written word", dout, 8'h3C);
        ras_n = 1; tick(2);
        check("R7", "held with RAS high", dq_oe, 1);
        ras_n = 0; tick(1);
        check("R7", "hidden kind", op_kind, 4);
        check("R7", "hidden row", refresh_row, 2);
        check("R7", "hidden keeps data", dout, 8'h3C);
        check("R7", "hidden keeps drive", dq_oe, 1);
        ras_n = 1; tick(1);
        cas_n = 1; tick(1);
        check("R6", "release after hidden", dq_oe, 0);

        // Self-refresh
        oe_n = 1;
        cas_n = 0; tick(1);
        ras_n = 0; tick(SR - 1);
        check("R8", "not yet self", self_refresh, 0);
        tick(2);
        check("R8", "self entered", self_refresh, 1);
        check("R8", "self kind", op_kind, 6);
        ras_n = 1; tick(1);
        check("R8", "self exit", self_refresh, 0);
        cas_n = 1; tick(1);

        // Stray column strobe
        cas_n = 0; tick(2);
        cas_n = 1; tick(1);
        check("R9", "stray CAS flagged", proto_err, 1);
        tick(1);
        check("R9", "flag is a pulse", proto_err, 0);

        tick(3);
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule